// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a 256-word, 9-bit first-in first-out buffer whose write side and read side run on separate, unrelated clocks. It reports four active-low status flags. The empty and almost-empty flags belong to the read clock domain. The full and almost-full flags belong to the write clock domain. Both pointers cross between the domains as gray code through two-stage synchronizers, so each flag is built from a local pointer and a delayed copy of the remote one.

One control input has two roles. The block samples it on clock edges while reset is held low, and that sample fixes its role until the next reset. If it was high, it is a second write enable that must be high for a write. If it was low, it is a load strobe. While the strobe is low, write-clock edges with write enable 1 low store threshold offsets instead of data. Read-clock edges with both read enables low return those offsets on the read data output. The two thresholds reset to 7, and each one can be reprogrammed.

Read data is registered, and an output-valid signal marks each word that leaves the buffer.

Top module: `dualclk_pflag_fifo`

## Requirements
- R1: While rstN is low, both pointers return to the first location. emptyN and almostEmptyN are low, fullN and almostFullN are high, and rdValid is low.
- R2: wrEn2Ld is sampled on the write and read clock edges while rstN is low. A high sample selects two-enable mode. A low sample selects load mode, in which wrEn2Ld acts as the offset load strobe.
- R3: In two-enable mode, a rising wrClk edge stores wrData only when wrEn1N is low and wrEn2Ld is high; with wrEn2Ld low nothing is stored. In load mode, wrEn1N low with wrEn2Ld high stores a word.
- R4: Words leave in the order they were stored. A word appears on rdData with rdValid high for one read-clock cycle, on the rdClk edge after the edge that accepted the read.
- R5: A read is accepted on a rising rdClk edge only when rdEn1N and rdEn2N are both low; either one high alone inhibits it.
- R6: fullN is low while 256 words are stored. Writes made while fullN is low are discarded and overwrite nothing.
- R7: emptyN is low while no word is stored, and reads made while emptyN is low produce no rdValid pulse.
- R8: almostEmptyN is low while the stored count is at most the almost-empty offset. That offset is 7 after reset.
- R9: almostFullN is low while the stored count is at least 256 minus the almost-full offset. That offset is 7 after reset, so the flag is low from 249 words.
- R10: In load mode, a wrClk edge with wrEn1N and wrEn2Ld both low stores wrData[7:0] as an offset and writes no data word. Successive loads after reset fill the almost-empty offset first, then the almost-full offset, and then alternate.
- R11: In load mode, a rdClk edge with wrEn2Ld low and both read enables low returns an offset, zero-extended to 9 bits, on rdData one edge later with rdValid high. Successive readbacks return the almost-empty offset first, then the almost-full offset, and leave the stored words untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Active-low reset for both domains |
| wrEn1N | input | 1 | Active-low write enable 1 |
| wrEn2Ld | input | 1 | Second write enable or offset load strobe, chosen at reset |
| wrData | input | 9 | Write data, or offset value in load accesses |
| rdEn1N | input | 1 | Active-low read enable 1 |
| rdEn2N | input | 1 | Active-low read enable 2 |
| rdData | output | 9 | Registered read data or offset readback |
| rdValid | output | 1 | High for one cycle when rdData carries a new word |
| emptyN | output | 1 | Empty flag, low active, read clock domain |
| almostEmptyN | output | 1 | Almost-empty flag, low active, read clock domain |
| almostFullN | output | 1 | Almost-full flag, low active, write clock domain |
| fullN | output | 1 | Full flag, low active, write clock domain |

## Verification
Read data is due one rdClk edge after the edge that accepts the read. The bench therefore samples rdData and rdValid on the falling read-clock edge, where the scoreboard monitor pops one expected word for each rdValid pulse. Read-side flags depend on writes only after the gray pointer has passed through two read-clock synchronizer stages, and write-side flags depend on reads the same way, so every flag check waits six cycles of the clock that owns the flag. Inhibited writes and reads are checked at the ports through unchanged flags and the absence of extra rdValid pulses.

// File: rtl/dualclk_pflag_fifo_pkg.sv
package dualclk_pflag_fifo_pkg;
  // Write-side strobes issued by the control to the datapath
  typedef struct packed {
    logic memWr;   // store a data word
    logic offWr;   // store an offset word
    logic offSel;  // 0: almost-empty offset, 1: almost-full offset
  } wr_strobe_t;

  // Read-side strobes issued by the control to the datapath
  typedef struct packed {
    logic memRd;   // fetch a data word
    logic offRd;   // fetch an offset word
    logic offSel;  // 0: almost-empty offset, 1: almost-full offset
  } rd_strobe_t;
endpackage

// File: rtl/ptr_sync.sv
module ptr_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= grayIn;
      stage2 <= stage1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign binOut[i] = ^stage2[W-1:i];
  end
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import dualclk_pflag_fifo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn1N,
  input  logic              wrEn2Ld,
  input  logic              rdEn1N,
  input  logic              rdEn2N,
  input  logic [ADDR_W-1:0] aeOff,
  input  logic [ADDR_W-1:0] afOff,
  output wr_strobe_t        wrStb,
  output rd_strobe_t        rdStb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              emptyN,
  output logic              almostEmptyN,
  output logic              almostFullN,
  output logic              fullN
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
  localparam logic [PTR_W:0]   DEPTH_X  = (PTR_W+1)'(DEPTH);

  logic pflagW, pflagR;
  logic [PTR_W-1:0] wrPtr, wrGray, rdPtr, rdGray;
  logic [PTR_W-1:0] rdPtrW, wrPtrR, wrNext, rdNext;
  logic [PTR_W-1:0] countW, countR;
  logic wrSel, rdSel, rdBoth, ldActiveR;

  // Mode capture: sampled only while reset is held
  always_ff @(posedge wrClk) begin
    if (!rstN) pflagW <= ~wrEn2Ld;
  end
  always_ff @(posedge rdClk) begin
    if (!rstN) pflagR <= ~wrEn2Ld;
  end

  // Write domain
  assign wrNext = wrPtr + 1'b1;
  assign countW = wrPtr - rdPtrW;
  assign fullN = (countW != FULL_CNT);
  assign almostFullN = ({1'b0, countW} + {2'b0, afOff}) < DEPTH_X;

  assign wrStb.memWr  = ~wrEn1N & wrEn2Ld & fullN;
  assign wrStb.offWr  = pflagW & ~wrEn1N & ~wrEn2Ld;
  assign wrStb.offSel = wrSel;
  assign wrAddr = wrPtr[ADDR_W-1:0];

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      wrGray <= '0;
      wrSel  <= 1'b0;
    end else begin
      if (wrStb.memWr) begin
        wrPtr  <= wrNext;
        wrGray <= wrNext ^ (wrNext >> 1);
      end
      if (wrStb.offWr) wrSel <= ~wrSel;
    end
  end

  ptr_sync #(.W(PTR_W)) u_rd2wr (.clk(wrClk), .rstN(rstN), .grayIn(rdGray), .binOut(rdPtrW));

  // Read domain
  assign rdNext = rdPtr + 1'b1;
  assign countR = wrPtrR - rdPtr;
  assign emptyN = (countR != '0);
  assign almostEmptyN = countR > {1'b0, aeOff};

  assign rdBoth    = ~rdEn1N & ~rdEn2N;
  assign ldActiveR = pflagR & ~wrEn2Ld;
  assign rdStb.memRd  = rdBoth & ~ldActiveR & emptyN;
  assign rdStb.offRd  = rdBoth & ldActiveR;
  assign rdStb.offSel = rdSel;
  assign rdAddr = rdPtr[ADDR_W-1:0];

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      rdGray <= '0;
      rdSel  <= 1'b0;
    end else begin
      if (rdStb.memRd) begin
        rdPtr  <= rdNext;
        rdGray <= rdNext ^ (rdNext >> 1);
      end
      if (rdStb.offRd) rdSel <= ~rdSel;
    end
  end

  ptr_sync #(.W(PTR_W)) u_wr2rd (.clk(rdClk), .rstN(rstN), .grayIn(wrGray), .binOut(wrPtrR));

  // Assertions
  assert_no_overflow_R6: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |=> $stable(wrPtr));
  assert_count_bound_R6: assert property (@(posedge wrClk) disable iff (!rstN)
    countW <= FULL_CNT);
  assert_no_underflow_R7: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |=> $stable(rdPtr));
  assert_gray_step_R4: assert property (@(posedge wrClk) disable iff (!rstN)
    $onehot0(wrGray ^ $past(wrGray)));
  assert_empty_in_ae_R8: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN);
  assert_full_in_af_R9: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !almostFullN);
  assert_load_holds_ptr_R11: assert property (@(posedge rdClk) disable iff (!rstN)
    ldActiveR |=> $stable(rdPtr));
endmodule

// File: rtl/fifo_dpath.sv
module fifo_dpath
  import dualclk_pflag_fifo_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int DEPTH   = 256,
  parameter int ADDR_W  = $clog2(DEPTH),
  parameter int DEF_OFF = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  wr_strobe_t        wrStb,
  input  rd_strobe_t        rdStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] aeOff,
  output logic [ADDR_W-1:0] afOff
);
  localparam logic [ADDR_W-1:0] OFF_RST = ADDR_W'(DEF_OFF);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] offOut;

  always_ff @(posedge wrClk) begin
    if (wrStb.memWr) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeOff <= OFF_RST;
      afOff <= OFF_RST;
    end else if (wrStb.offWr) begin
      if (wrStb.offSel) afOff <= wrData[ADDR_W-1:0];
      else              aeOff <= wrData[ADDR_W-1:0];
    end
  end

  assign offOut = rdStb.offSel ? afOff : aeOff;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdStb.memRd | rdStb.offRd;
      if (rdStb.memRd)      rdData <= mem[rdAddr];
      else if (rdStb.offRd) rdData <= DATA_W'(offOut);
    end
  end

  assert_offset_hold_R10: assert property (@(posedge wrClk) disable iff (!rstN)
    !wrStb.offWr |=> $stable(aeOff) && $stable(afOff));
  assert_valid_after_read_R4: assert property (@(posedge rdClk) disable iff (!rstN)
    rdStb.memRd |=> rdValid);
endmodule

// File: rtl/dualclk_pflag_fifo.sv
module dualclk_pflag_fifo
  import dualclk_pflag_fifo_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int DEPTH   = 256,
  parameter int DEF_OFF = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn1N,
  input  logic              wrEn2Ld,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn1N,
  input  logic              rdEn2N,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              emptyN,
  output logic              almostEmptyN,
  output logic              almostFullN,
  output logic              fullN
);
  localparam int ADDR_W = $clog2(DEPTH);

  wr_strobe_t wrStb;
  rd_strobe_t rdStb;
  logic [ADDR_W-1:0] wrAddr, rdAddr, aeOff, afOff;

  fifo_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn1N(wrEn1N), .wrEn2Ld(wrEn2Ld), .rdEn1N(rdEn1N), .rdEn2N(rdEn2N),
    .aeOff(aeOff), .afOff(afOff), .wrStb(wrStb), .rdStb(rdStb),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN),
    .almostFullN(almostFullN), .fullN(fullN)
  );

  fifo_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DEF_OFF(DEF_OFF)) u_dpath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrStb(wrStb), .rdStb(rdStb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .aeOff(aeOff), .afOff(afOff)
  );
endmodule

// File: tb/tb_dualclk_pflag_fifo.sv
module tb_dualclk_pflag_fifo;
  logic wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0;
  logic wrEn1N = 1'b1, wrEn2Ld = 1'b1, rdEn1N = 1'b1, rdEn2N = 1'b1;
  logic [8:0] wrData = '0;
  logic [8:0] rdData;
  logic rdValid, emptyN, almostEmptyN, almostFullN, fullN;

  int checks = 0, errors = 0, pops = 0;
  bit done = 1'b0;
  logic [8:0] expQ[$];

  dualclk_pflag_fifo dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn1N(wrEn1N), .wrEn2Ld(wrEn2Ld),
    .wrData(wrData), .rdEn1N(rdEn1N), .rdEn2N(rdEn2N), .rdData(rdData), .rdValid(rdValid),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN), .almostFullN(almostFullN), .fullN(fullN)
  );

  initial forever #2 wrClk = ~wrClk;
  initial begin #1; forever #2 rdClk = ~rdClk; end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: one pop per output pulse (R4)
  always @(negedge rdClk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4/R7 unexpected output actual=%0d expected=none", rdData);
      end else begin
        chk("R4 output order", int'(rdData), int'(expQ.pop_front()));
        pops++;
      end
    end
  end

  task automatic doReset(input logic pin);
    rstN = 1'b0; wrEn2Ld = pin; wrEn1N = 1'b1; rdEn1N = 1'b1; rdEn2N = 1'b1;
    repeat (4) @(negedge wrClk);
    chk("R1 emptyN in reset", emptyN, 0);
    chk("R1 almostEmptyN in reset", almostEmptyN, 0);
    chk("R1 fullN in reset", fullN, 1);
    chk("R1 almostFullN in reset", almostFullN, 1);
    chk("R1 rdValid in reset", rdValid, 0);
    rstN = 1'b1;
    @(negedge wrClk) wrEn2Ld = 1'b1;
  endtask

  task automatic writeWords(input int n, input int base, input bit push);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrEn1N = 1'b0; wrData = 9'(base + i);
      if (push) expQ.push_back(9'(base + i));
    end
    @(negedge wrClk) wrEn1N = 1'b1;
  endtask

  task automatic readWords(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rdClk); rdEn1N = 1'b0; rdEn2N = 1'b0;
    end
    @(negedge rdClk); rdEn1N = 1'b1; rdEn2N = 1'b1;
  endtask

  task automatic settleR(); repeat (6) @(negedge rdClk); endtask
  task automatic settleW(); repeat (6) @(negedge wrClk); endtask

  initial begin
    // ---------------- two-enable mode ----------------
    doReset(1'b1);
    settleR();
    chk("R1 emptyN after reset", emptyN, 0);
    chk("R1 almostFullN after reset", almostFullN, 1);

    // R3 / R2: second enable low blocks the write, and loads no offset
    @(negedge wrClk); wrEn2Ld = 1'b0; wrEn1N = 1'b0; wrData = 9'd1;
    repeat (2) @(negedge wrClk);
    wrEn1N = 1'b1; wrEn2Ld = 1'b1;
    settleR();
    chk("R3 write with enable 2 low ignored (emptyN)", emptyN, 0);

    writeWords(7, 'h100, 1'b1);
    settleR();
    chk("R3 write accepted (emptyN)", emptyN, 1);
    chk("R8 count 7 almostEmptyN", almostEmptyN, 0);
    chk("R2 default offset kept in two-enable mode", almostEmptyN, 0);
    writeWords(1, 'h107, 1'b1);
    settleR();
    chk("R8 count 8 almostEmptyN", almostEmptyN, 1);

    // R5: one read enable alone does nothing
    @(negedge rdClk); rdEn1N = 1'b0;
    repeat (3) @(negedge rdClk);
    rdEn1N = 1'b1; rdEn2N = 1'b0;
    repeat (3) @(negedge rdClk);
    rdEn2N = 1'b1;
    settleR();
    chk("R5 single enable no read (pops)", pops, 0);
    chk("R5 single enable count kept (almostEmptyN)", almostEmptyN, 1);

    readWords(8);
    settleR();
    chk("R4 eight words out", pops, 8);
    chk("R7 emptyN after drain", emptyN, 0);
    readWords(2);
    settleR();
    chk("R7 reads on empty ignored", pops, 8);

    // fill toward full
    writeWords(248, 'h020, 1'b1);
    settleW();
    chk("R9 count 248 almostFullN", almostFullN, 1);
    writeWords(1, 'h118, 1'b1);
    settleW();
    chk("R9 count 249 almostFullN", almostFullN, 0);
    chk("R6 count 249 fullN", fullN, 1);
    writeWords(7, 'h140, 1'b1);
    settleW();
    chk("R6 count 256 fullN", fullN, 0);
    writeWords(3, 'h1F0, 1'b0);   // discarded
    settleW();
    chk("R6 still full after discarded writes", fullN, 0);
    readWords(256);
    settleR();
    chk("R6 exactly 256 words out", pops, 264);
    chk("R7 emptyN after full drain", emptyN, 0);

    // ---------------- load mode ----------------
    doReset(1'b0);
    @(negedge wrClk); wrEn2Ld = 1'b0; wrEn1N = 1'b0; wrData = 9'd3;
    @(negedge wrClk); wrData = 9'd10;
    @(negedge wrClk); wrEn1N = 1'b1;
    settleR();
    chk("R10 offset load writes no data (emptyN)", emptyN, 0);
    chk("R2 low pin selected load mode (emptyN)", emptyN, 0);
    expQ.push_back(9'd3);
    expQ.push_back(9'd10);
    readWords(2);
    settleR();
    chk("R11 two offsets read back", pops, 266);
    chk("R11 readback leaves buffer empty", emptyN, 0);
    @(negedge wrClk) wrEn2Ld = 1'b1;

    writeWords(3, 'h060, 1'b1);
    settleR();
    chk("R8 programmed offset 3, count 3", almostEmptyN, 0);
    chk("R3 load-mode write accepted", emptyN, 1);
    writeWords(1, 'h063, 1'b1);
    settleR();
    chk("R8 programmed offset 3, count 4", almostEmptyN, 1);
    writeWords(241, 'h080, 1'b1);
    settleW();
    chk("R9 programmed offset 10, count 245", almostFullN, 1);
    writeWords(1, 'h171, 1'b1);
    settleW();
    chk("R9 programmed offset 10, count 246", almostFullN, 0);
    readWords(246);
    settleR();
    chk("R4 all load-mode words out", pops, 512);
    chk("R4 scoreboard empty at end", expQ.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule